// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable logic domain up and down on command. A power-on request closes the domain's power switch at the weakest inrush-current setting. If the power-good status does not come up within a bounded wait, the setting is raised one step and the wait starts again, for at most four steps. Once power-good is seen, the sequencer releases electrical isolation and requests a memory repair. Functional isolation is released only after repair-done returns. A power-off request undoes these steps in the opposite order. All timeouts are counted in microsecond ticks supplied from outside, so the wait limits do not depend on the clock frequency.

Every control step is registered and lands on its own clock edge, which makes the ordering visible at the pins. Software sees a packed status word along with busy, powered and error flags. Requests that arrive while a sequence is running are dropped.

States:
- `ST_IDLE`: waits for a request.
- `ST_RAMP`: closes the switch or raises the inrush code, and reloads the timer.
- `ST_WAIT_PG`: waits for power-good.
- `ST_PG_FAIL`: power-good timeout cleanup.
- `ST_REL_EISO`: releases electrical isolation.
- `ST_REQ_REPAIR`: raises the repair request.
- `ST_WAIT_REPAIR`: waits for repair-done.
- `ST_REL_FISO`: releases functional isolation.
- `ST_REP_UNISO`: first step of repair-timeout cleanup.
- `ST_REP_CUT`: second step of repair-timeout cleanup.
- `ST_OFF_FISO`, `ST_OFF_EISO`, `ST_OFF_CUT`: the three power-off steps.

Transitions:
- `ST_IDLE` to `ST_RAMP`: on power-on while the switch is open.
- `ST_IDLE` stays in `ST_IDLE`: on power-on while the switch is already closed.
- `ST_IDLE` to `ST_OFF_FISO`: on power-off.
- `ST_RAMP` to `ST_WAIT_PG`: always.
- `ST_WAIT_PG` to `ST_REL_EISO`: on power-good.
- `ST_WAIT_PG` to `ST_RAMP`: on timeout below code 3.
- `ST_WAIT_PG` to `ST_PG_FAIL`: on timeout at code 3.
- `ST_PG_FAIL` to `ST_IDLE`: always.
- `ST_REL_EISO` to `ST_REQ_REPAIR` to `ST_WAIT_REPAIR`: always.
- `ST_WAIT_REPAIR` to `ST_REL_FISO`: on repair-done.
- `ST_WAIT_REPAIR` to `ST_REP_UNISO`: on timeout.
- `ST_REL_FISO` to `ST_IDLE`: always.
- `ST_REP_UNISO` to `ST_REP_CUT` to `ST_IDLE`: always.
- `ST_OFF_FISO` to `ST_OFF_EISO` to `ST_OFF_CUT` to `ST_IDLE`: always.

Top module: `pds_sequencer`

## Requirements
- R1: After reset, all control outputs (switch enable, inrush code, both isolation releases, repair request) are 0. Busy, powered and error are 0, and the status word is 0 while power-good and repair-done are low.
- R2: A power-on request while the switch enable is already 1 changes no control output, keeps busy at 0 and clears the error flag.
- R3: Power-on first asserts the switch enable with inrush code 0. Each further step raises the code by one, up to 3. The code is nonzero only while the switch enable is 1.
- R4: At each inrush step the timer is reloaded, and the step lasts exactly PG_WAIT_US microsecond ticks unless power-good arrives first.
- R5: If power-good is still absent when the code-3 wait expires, switch enable and inrush code both drop to 0 in one step, error goes to 1, and electrical isolation is never released.
- R6: After power-good, electrical isolation is released (output 1). On a later clock edge the repair request rises. Electrical isolation is released only while the switch enable is 1.
- R7: Functional isolation is released only after repair-done is seen within REPAIR_WAIT_US ticks, and only while electrical isolation is released. The sequence then ends with powered=1 and error=0.
- R8: On a repair timeout, electrical isolation is re-applied first. On the next step, switch enable, inrush code and repair request drop to 0 and error goes to 1.
- R9: Power-off re-applies functional isolation, then electrical isolation, and then clears switch enable, inrush code and repair request, on three successive steps.
- R10: Requests are ignored while busy is 1. While busy is 0, no control output changes on the next edge.
- R11: When power-on and power-off are requested in the same cycle, power-on wins.
- R12: The status word bits are:
  - bit 0: switch enable
  - bit 1: power-good
  - bit 2: electrical-isolation release
  - bit 3: repair request
  - bit 4: repair-done
  - bit 5: functional-isolation release
  - bits 14:13: inrush code
  - all other bits: 0
- R13: The two isolation releases never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cmd_on | input | 1 | Power-on request |
| cmd_off | input | 1 | Power-off request |
| pwr_good | input | 1 | Domain power-good status |
| repair_done | input | 1 | Memory repair complete |
| sw_en | output | 1 | Power switch enable |
| inrush_code | output | 2 | Inrush current limit code, 0 is lowest |
| eiso_release | output | 1 | 1 releases electrical isolation |
| fiso_release | output | 1 | 1 releases functional isolation |
| repair_req | output | 1 | Memory repair request |
| busy | output | 1 | Sequence in progress |
| powered | output | 1 | Domain fully up |
| error | output | 1 | Last sequence timed out |
| status | output | 16 | Packed status word |

## Verification
The bench builds the block with PG_WAIT_US=3 and REPAIR_WAIT_US=2, and issues a microsecond tick every 4 clocks. With these values a full four-step inrush ramp that ends in failure completes in about fifty cycles, and the exact tick count per step can be measured. A power-good model that answers only at or above a chosen inrush code then reaches every ramp length, from first-step success to total failure. A repair model that can withhold repair-done drives the repair-timeout cleanup path.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int INRUSH_W = 2;
    localparam int STATUS_W = 16;

    localparam int ST_BIT_SW    = 0;
    localparam int ST_BIT_PG    = 1;
    localparam int ST_BIT_EISO  = 2;
    localparam int ST_BIT_RREQ  = 3;
    localparam int ST_BIT_RDONE = 4;
    localparam int ST_BIT_FISO  = 5;
    localparam int ST_BIT_INR   = 13;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAMP,
        ST_WAIT_PG,
        ST_PG_FAIL,
        ST_REL_EISO,
        ST_REQ_REPAIR,
        ST_WAIT_REPAIR,
        ST_REL_FISO,
        ST_REP_UNISO,
        ST_REP_CUT,
        ST_OFF_FISO,
        ST_OFF_EISO,
        ST_OFF_CUT
    } pds_state_e;

endpackage

// File: rtl/pds_tick_timer.sv
module pds_tick_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm
    import pds_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_on,
    input  logic                cmd_off,
    input  logic                pwr_good,
    input  logic                repair_done,
    input  logic                tmr_expired,
    output logic                tmr_load,
    output logic                tmr_pick_pg,
    output logic                sw_en,
    output logic [INRUSH_W-1:0] inrush_code,
    output logic                eiso_release,
    output logic                fiso_release,
    output logic                repair_req,
    output logic                busy,
    output logic                error
);

    localparam logic [INRUSH_W-1:0] CODE_TOP = '1;

    pds_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_on) begin
                    state_d = sw_en ? ST_IDLE : ST_RAMP;
                end else if (cmd_off) begin
                    state_d = ST_OFF_FISO;
                end
            end
            ST_RAMP:       state_d = ST_WAIT_PG;
            ST_WAIT_PG: begin
                if (pwr_good) begin
                    state_d = ST_REL_EISO;
                end else if (tmr_expired) begin
                    state_d = (inrush_code == CODE_TOP) ? ST_PG_FAIL : ST_RAMP;
                end
            end
            ST_PG_FAIL:    state_d = ST_IDLE;
            ST_REL_EISO:   state_d = ST_REQ_REPAIR;
            ST_REQ_REPAIR: state_d = ST_WAIT_REPAIR;
            ST_WAIT_REPAIR: begin
                if (repair_done) begin
                    state_d = ST_REL_FISO;
                end else if (tmr_expired) begin
                    state_d = ST_REP_UNISO;
                end
            end
            ST_REL_FISO:   state_d = ST_IDLE;
            ST_REP_UNISO:  state_d = ST_REP_CUT;
            ST_REP_CUT:    state_d = ST_IDLE;
            ST_OFF_FISO:   state_d = ST_OFF_EISO;
            ST_OFF_EISO:   state_d = ST_OFF_CUT;
            ST_OFF_CUT:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // registered control outputs, one step per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en        <= 1'b0;
            inrush_code  <= '0;
            eiso_release <= 1'b0;
            fiso_release <= 1'b0;
            repair_req   <= 1'b0;
            error        <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_on) begin
                        error <= 1'b0;
                    end
                end
                ST_RAMP: begin
                    if (!sw_en) begin
                        sw_en <= 1'b1;
                    end else begin
                        inrush_code <= inrush_code + 1'b1;
                    end
                end
                ST_PG_FAIL: begin
                    sw_en       <= 1'b0;
                    inrush_code <= '0;
                    error       <= 1'b1;
                end
                ST_REL_EISO:   eiso_release <= 1'b1;
                ST_REQ_REPAIR: repair_req   <= 1'b1;
                ST_REL_FISO:   fiso_release <= 1'b1;
                ST_REP_UNISO:  eiso_release <= 1'b0;
                ST_REP_CUT: begin
                    sw_en       <= 1'b0;
                    inrush_code <= '0;
                    repair_req  <= 1'b0;
                    error       <= 1'b1;
                end
                ST_OFF_FISO:   fiso_release <= 1'b0;
                ST_OFF_EISO:   eiso_release <= 1'b0;
                ST_OFF_CUT: begin
                    sw_en       <= 1'b0;
                    inrush_code <= '0;
                    repair_req  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign tmr_load    = (state_q == ST_RAMP) || (state_q == ST_REQ_REPAIR);
    assign tmr_pick_pg = (state_q == ST_RAMP);

endmodule

// File: rtl/pds_status_pack.sv
module pds_status_pack
    import pds_pkg::*;
(
    input  logic                sw_en,
    input  logic                pwr_good,
    input  logic                eiso_release,
    input  logic                repair_req,
    input  logic                repair_done,
    input  logic                fiso_release,
    input  logic [INRUSH_W-1:0] inrush_code,
    output logic [STATUS_W-1:0] status
);

    always_comb begin
        status = '0;
        status[ST_BIT_SW]    = sw_en;
        status[ST_BIT_PG]    = pwr_good;
        status[ST_BIT_EISO]  = eiso_release;
        status[ST_BIT_RREQ]  = repair_req;
        status[ST_BIT_RDONE] = repair_done;
        status[ST_BIT_FISO]  = fiso_release;
        status[ST_BIT_INR +: INRUSH_W] = inrush_code;
    end

endmodule

// File: rtl/pds_sequencer.sv
module pds_sequencer
    import pds_pkg::*;
#(
    parameter int PG_WAIT_US     = 3,
    parameter int REPAIR_WAIT_US = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick,
    input  logic                cmd_on,
    input  logic                cmd_off,
    input  logic                pwr_good,
    input  logic                repair_done,
    output logic                sw_en,
    output logic [INRUSH_W-1:0] inrush_code,
    output logic                eiso_release,
    output logic                fiso_release,
    output logic                repair_req,
    output logic                busy,
    output logic                powered,
    output logic                error,
    output logic [STATUS_W-1:0] status
);

    localparam int WAIT_MAX = (PG_WAIT_US > REPAIR_WAIT_US) ? PG_WAIT_US : REPAIR_WAIT_US;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [CNT_W-1:0] PG_LOAD  = CNT_W'(PG_WAIT_US);
    localparam logic [CNT_W-1:0] REP_LOAD = CNT_W'(REPAIR_WAIT_US);

    logic             tmr_load;
    logic             tmr_pick_pg;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    assign tmr_val = tmr_pick_pg ? PG_LOAD : REP_LOAD;

    pds_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pds_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_on       (cmd_on),
        .cmd_off      (cmd_off),
        .pwr_good     (pwr_good),
        .repair_done  (repair_done),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_pick_pg  (tmr_pick_pg),
        .sw_en        (sw_en),
        .inrush_code  (inrush_code),
        .eiso_release (eiso_release),
        .fiso_release (fiso_release),
        .repair_req   (repair_req),
        .busy         (busy),
        .error        (error)
    );

    pds_status_pack u_status (
        .sw_en        (sw_en),
        .pwr_good     (pwr_good),
        .eiso_release (eiso_release),
        .repair_req   (repair_req),
        .repair_done  (repair_done),
        .fiso_release (fiso_release),
        .inrush_code  (inrush_code),
        .status       (status)
    );

    assign powered = sw_en && fiso_release;

endmodule

// File: rtl/pds_sequencer_chk.sv
module pds_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sw_en,
    input logic [1:0] inrush_code,
    input logic       eiso_release,
    input logic       fiso_release,
    input logic       repair_req
);

    assert_code_needs_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inrush_code != 2'd0) |-> sw_en);

    assert_eiso_needs_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eiso_release |-> sw_en);

    assert_fiso_needs_eiso_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fiso_release |-> eiso_release);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({sw_en, inrush_code, eiso_release, fiso_release, repair_req}));

    assert_iso_split_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(eiso_release) && !$stable(fiso_release)));

endmodule

bind pds_sequencer pds_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .sw_en        (sw_en),
    .inrush_code  (inrush_code),
    .eiso_release (eiso_release),
    .fiso_release (fiso_release),
    .repair_req   (repair_req)
);

// File: tb/pds_sequencer_test.sv
module pds_sequencer_test;

    localparam int PG_WAIT_US = 3;
    localparam int REP_WAIT_US = 2;
    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        cmd_on = 1'b0;
    logic        cmd_off = 1'b0;
    logic        pwr_good = 1'b0;
    logic        repair_done = 1'b0;
    logic        sw_en, eiso_release, fiso_release, repair_req;
    logic        busy, powered, error;
    logic [1:0]  inrush_code;
    logic [15:0] status;

    int errors = 0;
    int checks = 0;
    int pg_min = 4;
    bit rep_ok = 1'b1;
    int tick_total = 0;
    bit done = 1'b0;
    string quiet_tag = "R10";

    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic       m_sw, m_eiso, m_rreq, m_fiso;
    logic [1:0] m_inr;

    always #5 clk = ~clk;

    pds_sequencer #(.PG_WAIT_US(PG_WAIT_US), .REPAIR_WAIT_US(REP_WAIT_US)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .pwr_good(pwr_good), .repair_done(repair_done), .sw_en(sw_en),
        .inrush_code(inrush_code), .eiso_release(eiso_release),
        .fiso_release(fiso_release), .repair_req(repair_req), .busy(busy),
        .powered(powered), .error(error), .status(status)
    );

    function automatic logic [5:0] ctrl_now();
        return {fiso_release, repair_req, eiso_release, inrush_code, sw_en};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver side: record the next expected control vector
    task automatic push_exp(input string tag);
        exp_q.push_back({m_fiso, m_rreq, m_eiso, m_inr, m_sw});
        tag_q.push_back(tag);
    endtask

    // tick generator
    int tdiv = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            tdiv = (tdiv + 1) % TICK_DIV;
            us_tick = (tdiv == TICK_DIV - 1);
        end else begin
            us_tick = 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && us_tick) tick_total++;

    // environment models
    int pg_cnt = 0;
    always @(negedge clk) begin
        if (sw_en && (int'(inrush_code) >= pg_min)) pg_cnt++;
        else pg_cnt = 0;
        pwr_good = (pg_cnt >= 2);
        repair_done = repair_req && rep_ok;
    end

    // monitor: pop and compare on every control change
    logic [5:0] prev_ctrl = '0;
    int last_tick = 0;
    always @(negedge clk) begin
        logic [5:0] cur;
        if (!rst_n) begin
            prev_ctrl = '0;
            last_tick = tick_total;
        end else begin
            cur = ctrl_now();
            if (cur != prev_ctrl) begin
                if (cur[2:1] > prev_ctrl[2:1])
                    chk((tick_total - last_tick) == PG_WAIT_US, "R4", "ticks per inrush step",
                        tick_total - last_tick, PG_WAIT_US);
                last_tick = tick_total;
                if (exp_q.size() == 0) begin
                    chk(1'b0, quiet_tag, "unexpected control change", cur, prev_ctrl);
                end else begin
                    logic [5:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cur == e, t, "control vector", cur, e);
                end
                prev_ctrl = cur;
            end
        end
    end

    task automatic issue(input bit on, input bit off);
        @(negedge clk);
        cmd_on = on;
        cmd_off = off;
        @(negedge clk);
        cmd_on = 1'b0;
        cmd_off = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, "expected steps left over", exp_q.size(), 0);
    endtask

    task automatic exp_ramp(input int last_code, input string req);
        m_sw = 1'b1; m_inr = 2'd0; push_exp(req);
        for (int c = 1; c <= last_code; c++) begin
            m_inr = 2'(c); push_exp(req);
        end
    endtask

    task automatic exp_up_tail();
        m_eiso = 1'b1; push_exp("R6");
        m_rreq = 1'b1; push_exp("R6");
        m_fiso = 1'b1; push_exp("R7");
    endtask

    task automatic exp_off();
        m_fiso = 1'b0; push_exp("R9");
        m_eiso = 1'b0; push_exp("R9");
        m_sw = 1'b0; m_inr = 2'd0; m_rreq = 1'b0; push_exp("R9");
    endtask

    initial begin
        m_sw = 0; m_inr = 0; m_eiso = 0; m_rreq = 0; m_fiso = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_now() == 6'd0, "R1", "controls after reset", ctrl_now(), 0);
        chk({busy, powered, error} == 3'b000, "R1", "flags after reset", {busy, powered, error}, 0);
        chk(status == 16'd0, "R1", "status after reset", status, 0);

        // R5: no power-good at any code
        pg_min = 4;
        exp_ramp(3, "R3");
        m_sw = 1'b0; m_inr = 2'd0; push_exp("R5");
        issue(1'b1, 1'b0);
        wait_idle("R5");
        chk(error == 1'b1, "R5", "error after power-good timeout", error, 1);
        chk(status == 16'd0, "R5", "status after failure", status, 0);

        // success at code 2, power-off pulse mid-sequence ignored (R10)
        pg_min = 2;
        exp_ramp(2, "R3");
        exp_up_tail();
        issue(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        issue(1'b0, 1'b1);
        wait_idle("R10");
        chk(powered == 1'b1, "R7", "powered after ramp", powered, 1);
        chk(error == 1'b0, "R7", "error cleared", error, 0);
        chk(status == 16'h403F, "R12", "status word when up at code 2", status, 16'h403F);

        // R2: already on, nothing happens
        quiet_tag = "R2";
        issue(1'b1, 1'b0);
        chk(busy == 1'b0, "R2", "busy on redundant request", busy, 0);
        wait_idle("R2");
        chk(powered == 1'b1, "R2", "still powered", powered, 1);
        quiet_tag = "R10";

        // power-off with a power-on pulse while busy
        exp_off();
        issue(1'b0, 1'b1);
        issue(1'b1, 1'b0);
        wait_idle("R9");
        chk(powered == 1'b0, "R9", "powered after off", powered, 0);
        chk(ctrl_now() == 6'd0, "R9", "controls after off", ctrl_now(), 0);

        // R11: both requests at once, power-good at first step
        pg_min = 0;
        exp_ramp(0, "R11");
        exp_up_tail();
        issue(1'b1, 1'b1);
        wait_idle("R11");
        chk(status == 16'h003F, "R12", "status word when up at code 0", status, 16'h003F);
        exp_off();
        issue(1'b0, 1'b1);
        wait_idle("R9");

        // R8: repair never completes
        pg_min = 1;
        rep_ok = 1'b0;
        exp_ramp(1, "R3");
        m_eiso = 1'b1; push_exp("R6");
        m_rreq = 1'b1; push_exp("R6");
        m_eiso = 1'b0; push_exp("R8");
        m_sw = 1'b0; m_inr = 2'd0; m_rreq = 1'b0; push_exp("R8");
        issue(1'b1, 1'b0);
        wait_idle("R8");
        chk(error == 1'b1, "R8", "error after repair timeout", error, 1);
        chk(powered == 1'b0, "R8", "powered after repair timeout", powered, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule